// File: doc/BRIEF.md
# Transmit Bit Retimer

This block sits between a microcontroller and a 1200 bit/s FSK modulator. The processor hands over transmit bits one at a time. It sets a level on a data pin and pulses a separate strobe pin. The block presents each bit to the modulator for exactly one baud period, counted in cycles of the 3.579545 MHz reference clock. An active-low, open-drain ready line pulls low whenever the block can take another bit, so the processor can use it as an interrupt or wake-up and never has to time the bits itself.

When mode control turns retiming off, or when the block is in zero-power mode, the data pin feeds the modulator directly. In that state the ready line is released and the baud timer is held cleared. When retiming is turned on, the block waits for the first strobe. That strobe puts its bit on the output at once and starts the timer, so the first period is full length. Each later bit waits in a one-bit holding register until the next baud boundary. If the processor misses a boundary, the output repeats the last bit.

Top module: `txRetimer`

## Requirements
- R1: While `retimeEn` is 0 or `powerDown` is 1, `txOut` equals `txData` combinationally.
- R2: `readyN` is released (high impedance, reads 1 through a pull-up) while `retimeEn` is 0 or `powerDown` is 1, and also during reset. It is driven 0 while retiming is active and the holding register is empty.
- R3: The first strobe after retiming becomes active drives its bit onto `txOut` and restarts the baud timer. From then on, every bit on `txOut` lasts exactly `BAUD_DIV` (default 2983) reference cycles, which is 1200 bit/s from 3.579545 MHz.
- R4: A bit strobed in while the timer runs appears on `txOut` at the next baud boundary.
- R5: A strobe takes effect on the third rising clock edge after the rising edge of `txStrobe` (two synchronizer stages plus edge detection). On that edge a running block releases `readyN`, and a first strobe leaves `readyN` low. `readyN` stays released until the next baud boundary and is driven low again on that boundary.
- R6: If no bit was strobed in before a boundary, `txOut` repeats the last bit for another full period and `readyN` stays low.
- R7: If a strobe takes effect on the same edge as a baud boundary, the boundary is handled first: the output repeats its bit, the new bit is held for the following boundary, and `readyN` is released from that edge.
- R8: Turning retiming off clears the timer and the holding register and returns the retimed output to mark (1). After retiming is turned back on, `txOut` stays 1 and `readyN` stays low, with no boundary occurring, until the first strobe.
- R9: After reset the retimed output is mark (1), the holding register is empty and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (3.579545 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| retimeEn | input | 1 | Retiming enable from mode control |
| powerDown | input | 1 | Zero-power mode; overrides retimeEn |
| txData | input | 1 | Transmit bit from the processor |
| txStrobe | input | 1 | Strobe from the processor; its rising edge loads `txData` |
| txOut | output | 1 | Bit to the modulator |
| readyN | output | 1 | Open-drain request for the next bit: 0 or high impedance |

## Verification
Two events can land on the same clock edge: the baud-boundary transfer and the synchronized strobe load. The bench lets a period pass with no bit supplied. It then raises the strobe three cycles before the boundary, so the load takes effect on the boundary edge itself. The scoreboard expects the old bit to repeat for one more period and the new bit to follow it. The bench also expects `readyN` to read released from the boundary cycle onward, where an ordinary boundary would pull it low.

// File: rtl/txRetimePkg.sv
`timescale 1ns/1ps
package txRetimePkg;
  // One-cycle strobes from control to datapath.
  typedef struct packed {
    logic clearAll;   // retiming inactive: flush state
    logic startLoad;  // first strobe: bit straight to output
    logic holdLoad;   // later strobe: bit into holding register
    logic tickXfer;   // baud boundary: holding register to output
  } retimeCmd_t;
endpackage

// File: rtl/txStrobeSync.sv
`timescale 1ns/1ps
module txStrobeSync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/txRetimeCtrl.sv
`timescale 1ns/1ps
module txRetimeCtrl import txRetimePkg::*; #(
  parameter int unsigned BAUD_DIV    = 2983,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       strobeIn,
  output retimeCmd_t cmd,
  output logic       running,
  output logic       strobeEdge
);
  localparam int unsigned CW = $clog2(BAUD_DIV);
  localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

  logic          strobeSync;
  logic          strobePrev;
  logic [CW-1:0] baudCnt;
  logic          atLast;

  txStrobeSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (strobeIn),
    .syncOut (strobeSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeSync;

  assign strobeEdge = strobeSync & ~strobePrev;
  assign atLast     = (baudCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      baudCnt <= '0;
    end else if (!active) begin
      running <= 1'b0;
      baudCnt <= '0;
    end else if (strobeEdge && !running) begin
      running <= 1'b1;
      baudCnt <= '0;
    end else if (running) begin
      baudCnt <= atLast ? '0 : baudCnt + 1'b1;
    end
  end

  always_comb begin
    cmd.clearAll  = !active;
    cmd.startLoad = active && strobeEdge && !running;
    cmd.holdLoad  = active && strobeEdge && running;
    cmd.tickXfer  = active && running && atLast;
  end
endmodule

// File: rtl/txRetimeData.sv
`timescale 1ns/1ps
module txRetimeData import txRetimePkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  retimeCmd_t cmd,
  input  logic       dataIn,
  output logic       outBit,
  output logic       holdFull
);
  logic holdBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit   <= 1'b1;
      holdBit  <= 1'b1;
      holdFull <= 1'b0;
    end else if (cmd.clearAll) begin
      outBit   <= 1'b1;
      holdBit  <= 1'b1;
      holdFull <= 1'b0;
    end else begin
      if (cmd.startLoad) begin
        outBit   <= dataIn;
        holdFull <= 1'b0;
      end
      // boundary first, then a same-edge load refills the holder
      if (cmd.tickXfer) begin
        if (holdFull) outBit <= holdBit;
        holdFull <= 1'b0;
      end
      if (cmd.holdLoad) begin
        holdBit  <= dataIn;
        holdFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txRetimer.sv
`timescale 1ns/1ps
module txRetimer import txRetimePkg::*; #(
  parameter int unsigned BAUD_DIV    = 2983,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic retimeEn,
  input  logic powerDown,
  input  logic txData,
  input  logic txStrobe,
  output logic txOut,
  output logic readyN
);
  retimeCmd_t cmd;
  logic active;
  logic running;
  logic strobeEdge;
  logic outBit;
  logic holdFull;
  logic readyDrive;
  logic baudTick;

  assign active = retimeEn && !powerDown;

  txRetimeCtrl #(.BAUD_DIV(BAUD_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .active     (active),
    .strobeIn   (txStrobe),
    .cmd        (cmd),
    .running    (running),
    .strobeEdge (strobeEdge)
  );

  txRetimeData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .dataIn   (txData),
    .outBit   (outBit),
    .holdFull (holdFull)
  );

  assign baudTick   = cmd.tickXfer;
  assign readyDrive = rstN && active && !holdFull;
  assign txOut      = active ? outBit : txData;
  assign readyN     = readyDrive ? 1'b0 : 1'bz;
endmodule

// File: rtl/txRetimerChecker.sv
`timescale 1ns/1ps
module txRetimerChecker #(
  parameter int unsigned BAUD_DIV = 2983
) (
  input logic clk,
  input logic rstN,
  input logic retimeEn,
  input logic powerDown,
  input logic txOut,
  input logic readyDrive,
  input logic baudTick,
  input logic strobeEdge,
  input logic running
);
  logic on;
  int unsigned gap;
  assign on = retimeEn && !powerDown;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                              gap <= 0;
    else if (!on)                           gap <= 0;
    else if (baudTick || (strobeEdge && !running)) gap <= 0;
    else                                    gap <= gap + 1;

  // R2
  a_r2_release_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !on |-> !readyDrive);
  // R3
  a_r3_full_period: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> (gap == BAUD_DIV - 1));
  a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> running);
  // R5
  a_r5_request_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    (on && baudTick && !strobeEdge) |=> (!on || readyDrive));
  a_r5_release_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (on && strobeEdge && running) |=> (!on || !readyDrive));
  // R6
  a_r6_repeat_on_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (on && baudTick && readyDrive) |=> (!on || $stable(txOut)));
endmodule

bind txRetimer txRetimerChecker #(.BAUD_DIV(BAUD_DIV)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .retimeEn   (retimeEn),
  .powerDown  (powerDown),
  .txOut      (txOut),
  .readyDrive (readyDrive),
  .baudTick   (baudTick),
  .strobeEdge (strobeEdge),
  .running    (running)
);

// File: tb/txRetimer_test.sv
`timescale 1ns/1ps
module txRetimer_test;
  localparam int unsigned DIV = 2983;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retimeEn = 1'b0;
  logic powerDown = 1'b0;
  logic txData = 1'b1;
  logic txStrobe = 1'b0;
  wire  txOut;
  wire  readyLine;
  pullup (readyLine);

  txRetimer #(.BAUD_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .retimeEn(retimeEn), .powerDown(powerDown),
    .txData(txData), .txStrobe(txStrobe), .txOut(txOut), .readyN(readyLine)
  );

  always #2.5 clk = ~clk;

  int unsigned ncnt = 0;           // rising edges so far
  always @(posedge clk) ncnt <= ncnt + 1;

  int nCmp = 0;
  int nBad = 0;
  bit summaryDone = 0;
  logic expQ[$];

  // plan kinds: 0 normal bit, 1 skip, 2 late (boundary) bit, 3 carry
  int planKind[16];
  logic planBit[16];
  int planLen;

  task automatic check(input string req, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b (edge %0d)", req, act, exp, ncnt);
    end
  endtask

  task automatic waitNeg(input int unsigned t);
    while (ncnt < t) @(negedge clk);
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    end
  endtask

  // Monitor: pops one expected bit per period, checks first and last cycle (R3, R4).
  task automatic runMonitor(input int unsigned e0, input int nPer);
    for (int k = 0; k < nPer; k++) begin
      logic e;
      waitNeg(e0 + k*DIV);
      if (expQ.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL R4: actual <empty queue> expected <bit> period %0d", k);
        return;
      end
      e = expQ[0];
      check("R3/R4 period start", txOut, e);
      waitNeg(e0 + k*DIV + DIV - 1);
      check("R3 period end", txOut, e);
      void'(expQ.pop_front());
    end
  endtask

  // First strobe: bit goes straight out, timer restarts (R3, R5).
  task automatic startFirst(input logic b, output int unsigned e0);
    int unsigned s;
    s = ncnt;
    txData = b; txStrobe = 1'b1;
    e0 = s + 3;
    expQ.push_back(b);
    waitNeg(s + 2);
    txStrobe = 1'b0;
    check("R8 idle mark before first load", txOut, 1'b1);
  endtask

  // Driver: pushes the expected bit of each following period.
  task automatic runStream(input int unsigned e0, input logic firstBit);
    logic lastBit;
    int unsigned base;
    lastBit = firstBit;
    waitNeg(e0);
    check("R5 first load keeps ready low", readyLine, 1'b0);
    for (int k = 0; k < planLen; k++) begin
      base = e0 + k*DIV;
      case (planKind[k])
        0: begin
          waitNeg(base + 20);
          check("R5 ready low after boundary", readyLine, 1'b0);
          txData = planBit[k]; txStrobe = 1'b1;
          expQ.push_back(planBit[k]);
          lastBit = planBit[k];
          waitNeg(base + 22);
          check("R5 ready still low before 3rd edge", readyLine, 1'b0);
          waitNeg(base + 23);
          check("R5 ready released on 3rd edge", readyLine, 1'b1);
          waitNeg(base + 30);
          txStrobe = 1'b0;
          waitNeg(base + DIV - 2);
          check("R5 ready held released", readyLine, 1'b1);
        end
        1: begin
          expQ.push_back(lastBit);
          waitNeg(base + DIV - 2);
          check("R6 ready stays low on underrun", readyLine, 1'b0);
        end
        2: begin
          expQ.push_back(lastBit);
          waitNeg(base + DIV - 3);
          txData = planBit[k]; txStrobe = 1'b1;
          waitNeg(base + DIV);
          check("R7 ready released on shared edge", readyLine, 1'b1);
          waitNeg(base + DIV + 10);
          txStrobe = 1'b0;
          expQ.push_back(planBit[k]);
          lastBit = planBit[k];
        end
        default: begin
          waitNeg(base + DIV - 2);
          check("R7 held bit keeps ready released", readyLine, 1'b1);
        end
      endcase
    end
  endtask

  initial begin
    int unsigned e0;
    // reset state (R9, R1, R2)
    repeat (3) @(negedge clk);
    check("R2 released in reset", readyLine, 1'b1);
    txData = 1'b0; #1;
    check("R1 passthrough 0", txOut, 1'b0);
    txData = 1'b1; #1;
    check("R1 passthrough 1", txOut, 1'b1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 ready released with retiming off", readyLine, 1'b1);

    // zero power overrides enable (R2)
    retimeEn = 1'b1; powerDown = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 released in zero power", readyLine, 1'b1);
    txData = 1'b0; #1;
    check("R1 passthrough in zero power", txOut, 1'b0);
    txData = 1'b1;
    powerDown = 1'b0;
    @(negedge clk);
    check("R2 ready low when active and empty", readyLine, 1'b0);
    check("R9 reset output is mark", txOut, 1'b1);

    // stream A
    planLen = 10;
    planKind[0]=0; planBit[0]=1;
    planKind[1]=0; planBit[1]=0;
    planKind[2]=0; planBit[2]=1;
    planKind[3]=1; planBit[3]=0;
    planKind[4]=0; planBit[4]=0;
    planKind[5]=2; planBit[5]=1;
    planKind[6]=3; planBit[6]=0;
    planKind[7]=0; planBit[7]=0;
    planKind[8]=1; planBit[8]=0;
    planKind[9]=0; planBit[9]=1;
    @(negedge clk);
    startFirst(1'b0, e0);
    fork
      runMonitor(e0, planLen + 1);
      runStream(e0, 1'b0);
    join
    check("R4 scoreboard drained", expQ.size() == 0, 1'b1);

    // disable mid-run (R1, R2, R8)
    @(negedge clk);
    retimeEn = 1'b0;
    @(negedge clk);
    check("R2 released when retiming off", readyLine, 1'b1);
    txData = 1'b0; #1;
    check("R1 passthrough after disable", txOut, 1'b0);
    txData = 1'b1;
    repeat (7) @(negedge clk);
    retimeEn = 1'b1;
    @(negedge clk);
    check("R8 mark after re-enable", txOut, 1'b1);
    check("R8 ready low after re-enable", readyLine, 1'b0);
    txData = 1'b0;
    repeat (4000) @(negedge clk);
    check("R8 no boundary before first strobe", txOut, 1'b1);
    check("R8 ready still low before first strobe", readyLine, 1'b0);

    // stream B after re-enable, arbitrary phase (R3)
    repeat (13) @(negedge clk);
    planLen = 3;
    planKind[0]=0; planBit[0]=1;
    planKind[1]=0; planBit[1]=1;
    planKind[2]=1; planBit[2]=0;
    startFirst(1'b0, e0);
    fork
      runMonitor(e0, planLen + 1);
      runStream(e0, 1'b0);
    join
    check("R4 scoreboard drained B", expQ.size() == 0, 1'b1);

    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual <running> expected <done>");
    summary();
    $finish;
  end
endmodule